// File: doc/BRIEF.md
# Pipeline Hazard Controller

This block decides, every cycle, how a five-stage in-order pipeline (fetch, decode, execute, memory, writeback) resolves conflicts between instructions in flight. It is purely combinational. It looks at the register numbers and control flags that the pipeline registers already carry. From them it produces operand bypass selects for the execute stage, hold enables for the fetch and decode registers, and clear signals for the decode and execute registers.

Each execute operand takes the freshest value available. The value from the memory stage is preferred over the writeback stage. If neither stage is writing the register, the operand comes from the register file. The register file is assumed to write in the first half of the cycle, so a reader in decode needs no bypass from writeback.

A load whose result is needed by the very next instruction cannot be bypassed in time. In that case the block holds fetch and decode and inserts a bubble into execute. Any instruction in decode, execute or memory that will write the program counter holds fetch and clears decode until the write lands. A branch resolved as taken in execute clears both younger stages.

Top module: `pipe_hazard_ctrl`

## Requirements
- R1: `byp_sel_a` is 2'b10 (take the memory-stage result) whenever `exe_src_a` equals `mem_dst` and `mem_wr_en` is 1.
- R2: When R1 does not apply, `byp_sel_a` is 2'b01 (take the writeback result) if `exe_src_a` equals `wb_dst` and `wb_wr_en` is 1. Otherwise it is 2'b00 (register file). A matching destination with its write enable at 0 gives no bypass.
- R3: When both the memory and writeback stages write the register named by an execute source, the select is 2'b10. The memory-stage match wins.
- R4: `byp_sel_b` follows the same rules as R1 to R3, applied to `exe_src_b`. The value 2'b11 never appears on either select.
- R5: `dec_hold` is 1 exactly when `exe_is_load` is 1 and `dec_src_a` or `dec_src_b` equals `exe_dst`.
- R6: `fetch_hold` is 1 exactly when the R5 condition holds or any of `pcw_dec`, `pcw_exe`, `pcw_mem` is 1.
- R7: `dec_clear` is 1 exactly when any of `pcw_dec`, `pcw_exe`, `pcw_mem`, `pcw_wb` or `exe_br_taken` is 1.
- R8: `exe_clear` is 1 exactly when the R5 condition holds or `exe_br_taken` is 1.
- R9: A program-counter write in writeback alone (`pcw_wb` = 1, no load-use match, no other flag set) clears decode but leaves `fetch_hold` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_src_a | input | 4 | First source register of the decode-stage instruction |
| dec_src_b | input | 4 | Second source register of the decode-stage instruction |
| exe_src_a | input | 4 | First source register of the execute-stage instruction |
| exe_src_b | input | 4 | Second source register of the execute-stage instruction |
| exe_dst | input | 4 | Destination register in execute |
| mem_dst | input | 4 | Destination register in memory |
| wb_dst | input | 4 | Destination register in writeback |
| mem_wr_en | input | 1 | Memory-stage instruction writes a register |
| wb_wr_en | input | 1 | Writeback-stage instruction writes a register |
| exe_is_load | input | 1 | Execute-stage instruction returns memory data to a register |
| pcw_dec | input | 1 | Decode-stage instruction writes the program counter |
| pcw_exe | input | 1 | Execute-stage instruction writes the program counter |
| pcw_mem | input | 1 | Memory-stage instruction writes the program counter |
| pcw_wb | input | 1 | Writeback-stage instruction writes the program counter |
| exe_br_taken | input | 1 | Branch in execute resolved as taken |
| byp_sel_a | output | 2 | Bypass select for execute operand A |
| byp_sel_b | output | 2 | Bypass select for execute operand B |
| fetch_hold | output | 1 | Hold the fetch stage (program counter) |
| dec_hold | output | 1 | Hold the decode pipeline register |
| dec_clear | output | 1 | Clear the decode pipeline register |
| exe_clear | output | 1 | Clear the execute pipeline register |

## Verification
Register numbers are drawn at random from a narrow range, so destination matches are common. The stimulus then covers single matches, matches masked by a disabled write enable, and the double match where memory and writeback name the same register; these cases separate the priority order of the bypass from a plain OR of the two hits. Program-counter flags and the taken branch are set one at a time and in mixtures. This shows which stages feed fetch hold and which feed only the decode clear, with the writeback-only write as the case that tells them apart. Load-use cases are tried with the match on either decode source and with the load flag cleared, which shows that a mere register match does not stall.

// File: rtl/pipe_hazard_pkg.sv
package pipe_hazard_pkg;

  localparam int BYP_W = 2;

  typedef enum logic [BYP_W-1:0] {
    BYP_RF  = 2'b00,
    BYP_WB  = 2'b01,
    BYP_MEM = 2'b10
  } byp_sel_e;

  // Priority: the younger (memory-stage) result beats the older one.
  function automatic byp_sel_e pick_bypass(input logic mem_hit, input logic wb_hit);
    if (mem_hit)     return BYP_MEM;
    else if (wb_hit) return BYP_WB;
    else             return BYP_RF;
  endfunction

  // A stage supplies a bypass only when it actually writes a register.
  function automatic logic dst_hit(input logic [7:0] src, input logic [7:0] dst,
                                   input logic wr_en);
    return wr_en && (src == dst);
  endfunction

endpackage

// File: rtl/operand_bypass.sv
module operand_bypass
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] mem_dst,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             mem_wr_en,
  input  logic             wb_wr_en,
  output logic             mem_hit,
  output logic             wb_hit,
  output logic [BYP_W-1:0] sel
);

  localparam int PAD = 8 - REG_W;

  always_comb begin
    mem_hit = dst_hit({{PAD{1'b0}}, src}, {{PAD{1'b0}}, mem_dst}, mem_wr_en);
    wb_hit  = dst_hit({{PAD{1'b0}}, src}, {{PAD{1'b0}}, wb_dst}, wb_wr_en);
    sel     = pick_bypass(mem_hit, wb_hit);
  end

endmodule

// File: rtl/stall_flush_ctrl.sv
module stall_flush_ctrl #(
  parameter int REG_W   = 4,
  parameter int NUM_SRC = 2
) (
  input  logic [NUM_SRC-1:0][REG_W-1:0] dec_src,
  input  logic [REG_W-1:0]              exe_dst,
  input  logic                          exe_is_load,
  input  logic                          pcw_dec,
  input  logic                          pcw_exe,
  input  logic                          pcw_mem,
  input  logic                          pcw_wb,
  input  logic                          exe_br_taken,
  output logic                          load_use,
  output logic                          pc_pending,
  output logic                          fetch_hold,
  output logic                          dec_hold,
  output logic                          dec_clear,
  output logic                          exe_clear
);

  logic [NUM_SRC-1:0] src_match;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign src_match[i] = (dec_src[i] == exe_dst);
  end

  always_comb begin
    load_use   = exe_is_load && (|src_match);
    pc_pending = pcw_dec || pcw_exe || pcw_mem;
    fetch_hold = load_use || pc_pending;
    dec_hold   = load_use;
    dec_clear  = pc_pending || pcw_wb || exe_br_taken;
    exe_clear  = load_use || exe_br_taken;
  end

endmodule

// File: rtl/pipe_hazard_ctrl.sv
module pipe_hazard_ctrl
  import pipe_hazard_pkg::*;
#(
  parameter int REG_W = 4
) (
  input  logic [REG_W-1:0] dec_src_a,
  input  logic [REG_W-1:0] dec_src_b,
  input  logic [REG_W-1:0] exe_src_a,
  input  logic [REG_W-1:0] exe_src_b,
  input  logic [REG_W-1:0] exe_dst,
  input  logic [REG_W-1:0] mem_dst,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             mem_wr_en,
  input  logic             wb_wr_en,
  input  logic             exe_is_load,
  input  logic             pcw_dec,
  input  logic             pcw_exe,
  input  logic             pcw_mem,
  input  logic             pcw_wb,
  input  logic             exe_br_taken,
  output logic [1:0]       byp_sel_a,
  output logic [1:0]       byp_sel_b,
  output logic             fetch_hold,
  output logic             dec_hold,
  output logic             dec_clear,
  output logic             exe_clear
);

  localparam int NUM_SRC = 2;

  logic [NUM_SRC-1:0][REG_W-1:0] exe_src;
  logic [NUM_SRC-1:0][REG_W-1:0] dec_src;
  logic [NUM_SRC-1:0][BYP_W-1:0] byp_sel;
  logic [NUM_SRC-1:0]            hit_mem;
  logic [NUM_SRC-1:0]            hit_wb;
  logic                          load_use;
  logic                          pc_pending;

  assign exe_src = {exe_src_b, exe_src_a};
  assign dec_src = {dec_src_b, dec_src_a};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_byp
    operand_bypass #(.REG_W(REG_W)) u_byp (
      .src       (exe_src[i]),
      .mem_dst   (mem_dst),
      .wb_dst    (wb_dst),
      .mem_wr_en (mem_wr_en),
      .wb_wr_en  (wb_wr_en),
      .mem_hit   (hit_mem[i]),
      .wb_hit    (hit_wb[i]),
      .sel       (byp_sel[i])
    );
  end

  assign byp_sel_a = byp_sel[0];
  assign byp_sel_b = byp_sel[1];

  stall_flush_ctrl #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) u_sfc (
    .dec_src      (dec_src),
    .exe_dst      (exe_dst),
    .exe_is_load  (exe_is_load),
    .pcw_dec      (pcw_dec),
    .pcw_exe      (pcw_exe),
    .pcw_mem      (pcw_mem),
    .pcw_wb       (pcw_wb),
    .exe_br_taken (exe_br_taken),
    .load_use     (load_use),
    .pc_pending   (pc_pending),
    .fetch_hold   (fetch_hold),
    .dec_hold     (dec_hold),
    .dec_clear    (dec_clear),
    .exe_clear    (exe_clear)
  );

endmodule

// File: rtl/pipe_hazard_chk.sv
module pipe_hazard_chk #(
  parameter int REG_W = 4
) (
  input logic [REG_W-1:0] dec_src_a,
  input logic [REG_W-1:0] dec_src_b,
  input logic [REG_W-1:0] exe_src_a,
  input logic [REG_W-1:0] exe_dst,
  input logic [REG_W-1:0] mem_dst,
  input logic [REG_W-1:0] wb_dst,
  input logic             mem_wr_en,
  input logic             wb_wr_en,
  input logic             exe_is_load,
  input logic             pcw_dec,
  input logic             pcw_exe,
  input logic             pcw_mem,
  input logic             pcw_wb,
  input logic             exe_br_taken,
  input logic [1:0]       byp_sel_a,
  input logic [1:0]       byp_sel_b,
  input logic [1:0]       hit_mem,
  input logic [1:0]       hit_wb,
  input logic             load_use,
  input logic             pc_pending,
  input logic             fetch_hold,
  input logic             dec_hold,
  input logic             dec_clear,
  input logic             exe_clear
);

  always_comb begin
    // R1: a memory-stage selection must be backed by a live register write
    if (byp_sel_a == 2'b10)
      assert_mem_byp_R1: assert (mem_wr_en && exe_src_a == mem_dst);
    // R2: a writeback selection must be backed by a live write, with no younger hit
    if (byp_sel_a == 2'b01)
      assert_wb_byp_R2: assert (wb_wr_en && exe_src_a == wb_dst && !hit_mem[0]);
    // R3: with both stages hitting, the younger result wins
    if (hit_mem[1] && hit_wb[1])
      assert_prio_R3: assert (byp_sel_b == 2'b10);
    // R4: no undefined select code on either operand
    assert_sel_code_R4: assert (byp_sel_a != 2'b11 && byp_sel_b != 2'b11);
    // R5: a decode hold needs a load in execute naming a decode source
    if (dec_hold)
      assert_hold_load_R5: assert (exe_is_load && (dec_src_a == exe_dst || dec_src_b == exe_dst));
    // R6: fetch holds whenever decode holds or a PC write is pending
    if (dec_hold || pc_pending)
      assert_fetch_hold_R6: assert (fetch_hold);
    // R7: decode clear only has these causes
    if (dec_clear)
      assert_dec_clear_R7: assert (pcw_dec || pcw_exe || pcw_mem || pcw_wb || exe_br_taken);
    // R8: execute clear tracks a bubble or a taken branch
    if (exe_clear)
      assert_exe_clear_R8: assert (load_use || exe_br_taken);
    // R9: a writeback-only PC write never holds fetch
    if (pcw_wb && !pcw_dec && !pcw_exe && !pcw_mem && !load_use)
      assert_wb_pcw_R9: assert (!fetch_hold && dec_clear);
  end

endmodule

bind pipe_hazard_ctrl pipe_hazard_chk #(.REG_W(REG_W)) u_chk (
  .dec_src_a    (dec_src_a),
  .dec_src_b    (dec_src_b),
  .exe_src_a    (exe_src_a),
  .exe_dst      (exe_dst),
  .mem_dst      (mem_dst),
  .wb_dst       (wb_dst),
  .mem_wr_en    (mem_wr_en),
  .wb_wr_en     (wb_wr_en),
  .exe_is_load  (exe_is_load),
  .pcw_dec      (pcw_dec),
  .pcw_exe      (pcw_exe),
  .pcw_mem      (pcw_mem),
  .pcw_wb       (pcw_wb),
  .exe_br_taken (exe_br_taken),
  .byp_sel_a    (byp_sel_a),
  .byp_sel_b    (byp_sel_b),
  .hit_mem      (hit_mem),
  .hit_wb       (hit_wb),
  .load_use     (load_use),
  .pc_pending   (pc_pending),
  .fetch_hold   (fetch_hold),
  .dec_hold     (dec_hold),
  .dec_clear    (dec_clear),
  .exe_clear    (exe_clear)
);

// File: tb/sim_pipe_hazard_ctrl.sv
module sim_pipe_hazard_ctrl;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic [3:0] dec_src_a, dec_src_b, exe_src_a, exe_src_b, exe_dst, mem_dst, wb_dst;
  logic mem_wr_en, wb_wr_en, exe_is_load;
  logic pcw_dec, pcw_exe, pcw_mem, pcw_wb, exe_br_taken;
  logic [1:0] byp_sel_a, byp_sel_b;
  logic fetch_hold, dec_hold, dec_clear, exe_clear;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  pipe_hazard_ctrl u0 (
    .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .exe_src_a(exe_src_a), .exe_src_b(exe_src_b),
    .exe_dst(exe_dst), .mem_dst(mem_dst), .wb_dst(wb_dst),
    .mem_wr_en(mem_wr_en), .wb_wr_en(wb_wr_en), .exe_is_load(exe_is_load),
    .pcw_dec(pcw_dec), .pcw_exe(pcw_exe), .pcw_mem(pcw_mem), .pcw_wb(pcw_wb),
    .exe_br_taken(exe_br_taken),
    .byp_sel_a(byp_sel_a), .byp_sel_b(byp_sel_b),
    .fetch_hold(fetch_hold), .dec_hold(dec_hold),
    .dec_clear(dec_clear), .exe_clear(exe_clear)
  );

  // Reference: bypass choice written as a case on the two hits.
  function automatic logic [1:0] ref_byp(input logic [3:0] s, input logic [3:0] md,
                                         input logic mw, input logic [3:0] wd, input logic ww);
    case ({mw && (s == md), ww && (s == wd)})
      2'b10, 2'b11: return 2'b10;
      2'b01:        return 2'b01;
      default:      return 2'b00;
    endcase
  endfunction

  function automatic logic ref_lu();
    return exe_is_load && ((dec_src_a == exe_dst) || (dec_src_b == exe_dst));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive_zero();
    {dec_src_a, dec_src_b, exe_src_a, exe_src_b, exe_dst, mem_dst, wb_dst} = '0;
    {mem_wr_en, wb_wr_en, exe_is_load} = '0;
    {pcw_dec, pcw_exe, pcw_mem, pcw_wb, exe_br_taken} = '0;
  endtask

  task automatic check_all();
    logic lu;
    logic pend;
    logic [1:0] ea;
    lu   = ref_lu();
    pend = pcw_dec | pcw_exe | pcw_mem;
    ea   = ref_byp(exe_src_a, mem_dst, mem_wr_en, wb_dst, wb_wr_en);
    if (ea == 2'b10 && wb_wr_en && exe_src_a == wb_dst) check("R3 byp_sel_a", byp_sel_a, ea);
    else if (ea == 2'b10)                                check("R1 byp_sel_a", byp_sel_a, ea);
    else                                                 check("R2 byp_sel_a", byp_sel_a, ea);
    check("R4 byp_sel_b", byp_sel_b, ref_byp(exe_src_b, mem_dst, mem_wr_en, wb_dst, wb_wr_en));
    check("R5 dec_hold", dec_hold, lu);
    check("R6 fetch_hold", fetch_hold, lu | pend);
    check("R7 dec_clear", dec_clear, pend | pcw_wb | exe_br_taken);
    check("R8 exe_clear", exe_clear, lu | exe_br_taken);
  endtask

  task automatic step();
    @(negedge clk);
    #1;
    check_all();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240917));
    drive_zero();
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Idle state: every register number 0, no enables -> nothing happens (R2)
    @(negedge clk); #1;
    check("R2 idle byp_sel_a", byp_sel_a, 0);
    check("R4 idle byp_sel_b", byp_sel_b, 0);
    check("R6 idle fetch_hold", fetch_hold, 0);
    check("R7 idle dec_clear", dec_clear, 0);
    check("R8 idle exe_clear", exe_clear, 0);

    // R3: double hit on both operands, memory stage wins
    drive_zero();
    exe_src_a = 4'd5; exe_src_b = 4'd5; mem_dst = 4'd5; wb_dst = 4'd5;
    mem_wr_en = 1; wb_wr_en = 1;
    step();
    check("R3 double hit a", byp_sel_a, 2);

    // R2: matching destination with write disabled gives no bypass
    mem_wr_en = 0; wb_wr_en = 0;
    step();
    check("R2 disabled write", byp_sel_a, 0);

    // R5: match with load flag cleared does not stall
    drive_zero();
    dec_src_b = 4'd7; exe_dst = 4'd7; exe_src_a = 4'd1;
    step();
    check("R5 no load no hold", dec_hold, 0);
    exe_is_load = 1;
    step();
    check("R5 load on src b", dec_hold, 1);

    // R9: writeback-only PC write
    drive_zero();
    exe_dst = 4'd3; dec_src_a = 4'd4; dec_src_b = 4'd4;
    pcw_wb = 1;
    step();
    check("R9 fetch_hold", fetch_hold, 0);
    check("R9 dec_clear", dec_clear, 1);

    // R6/R7: each pending flag alone
    for (int k = 0; k < 3; k++) begin
      drive_zero();
      exe_dst = 4'd9;
      {pcw_mem, pcw_exe, pcw_dec} = 3'b001 << k;
      step();
    end

    // R8: taken branch alone
    drive_zero();
    exe_dst = 4'd9; exe_br_taken = 1;
    step();
    check("R8 taken branch", exe_clear, 1);

    // Constrained random: narrow register range makes matches frequent
    for (int i = 0; i < 3000; i++) begin
      dec_src_a = 4'($urandom % 4);
      dec_src_b = 4'($urandom % 4);
      exe_src_a = 4'($urandom % 4);
      exe_src_b = 4'($urandom % 4);
      exe_dst   = 4'($urandom % 4);
      mem_dst   = 4'($urandom % 4);
      wb_dst    = ($urandom % 3 == 0) ? mem_dst : 4'($urandom % 4);
      if (i % 500 == 0) begin
        dec_src_a = 4'($urandom); exe_src_a = 4'($urandom);
        mem_dst = 4'($urandom); wb_dst = 4'($urandom);
      end
      mem_wr_en    = 1'($urandom);
      wb_wr_en     = 1'($urandom);
      exe_is_load  = 1'($urandom);
      pcw_dec      = ($urandom % 5 == 0);
      pcw_exe      = ($urandom % 5 == 0);
      pcw_mem      = ($urandom % 5 == 0);
      pcw_wb       = ($urandom % 5 == 0);
      exe_br_taken = ($urandom % 5 == 0);
      step();
    end

    finish_run();
  end

endmodule